// File: doc/BRIEF.md
# Pipelined Folding FIR Filter

This block is a fully parallel finite impulse response filter whose coefficients are fixed at elaboration time. On every clock where the clock enable is high it takes one input sample and produces one filtered output sample. A shift line keeps the recent samples. A fold stage combines mirrored samples. Each folded value feeds its own constant-coefficient multiplier, and a binary adder tree sums the products. A register follows every adder, so the longest path between registers is a single adder.

A parameter chooses how the impulse response is folded. Even symmetry adds mirrored samples. Odd symmetry subtracts them. No folding uses every coefficient on its own. Other parameters pick a signed or unsigned sample format, the number of output bits kept, and the coefficient vector. Out-of-range widths and tap counts stop elaboration: data and coefficient widths must be 4 to 24 bits, and the tap count must be 4 to 100. The clock enable lets a system run the filter at a fraction of its clock rate without gating the clock.

Top module: `fir_sym_pipe`

## Requirements
- R1: Let M be the multiplier count and LAT = 2 + ceil(log2 M). Let x(s) be the sample captured on the s-th enabled edge, where x(s) = 0 for s < 1. After E enabled edges, the full sum on the output is the sum over k = 0..NTAPS-1 of c(k)·x(E−LAT−k).
- R2: With FOLD = FOLD_EVEN, element k of COEFS (bits k·CW upward, two's complement) weights both tap k and tap NTAPS−1−k. For an odd NTAPS the centre tap has its own unpaired product. M = ceil(NTAPS/2).
- R3: With FOLD = FOLD_ODD, element k weights tap k, and its negation weights tap NTAPS−1−k. The centre tap of an odd NTAPS has weight zero. M = floor(NTAPS/2).
- R4: With FOLD = FOLD_NONE, each of the NTAPS elements of COEFS weights its own tap, and M = NTAPS.
- R5: SIGNED_IN = 1 reads x_in as two's complement. SIGNED_IN = 0 reads it as an unsigned magnitude.
- R6: FULL_W = DW + CW + 2 + ceil(log2 M). y_out is the two's complement value made of the OUT_W most significant bits of the FULL_W-bit sum, which equals the full sum shifted right arithmetically by FULL_W − OUT_W.
- R7: On an edge where ce is low, no sample is taken and y_out and out_valid keep their values.
- R8: out_valid is low until LAT+1 enabled edges have occurred since reset. After that it stays high.
- R9: While rst_n is low, y_out is zero and out_valid is low, independent of the clock.
- R10: After NTAPS+LAT consecutive enabled edges that capture a zero sample, y_out is zero.
- R11: Full-scale inputs held on every tap (most negative signed, largest unsigned) give the exact result without wraparound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce | input | 1 | Clock enable; while it is low, every register holds |
| x_in | input | DW | Input sample |
| y_out | output | OUT_W | Filtered sample, two's complement |
| out_valid | output | 1 | High once the first captured sample has reached the output |

## Verification
The bench builds three instances and drives all three with the same sample stream. The first uses even folding with an odd tap count of 7 and signed 8-bit data, so the unpaired centre product is exercised. The second uses odd folding with 7 taps and unsigned data, which covers the pre-subtractor, the dropped centre tap and the zero-extended sample path. The third uses no folding with 6 taps, 6-bit signed data and 12 kept output bits out of 17. Its adder tree is padded to 8 leaves and has one more stage of latency, and its output is truncated, which brings the arithmetic shift of negative sums within reach.

// File: rtl/fir_pkg.sv
package fir_pkg;

   typedef enum logic [1:0] {
      FOLD_NONE = 2'd0,
      FOLD_EVEN = 2'd1,
      FOLD_ODD  = 2'd2
   } fold_e;

   // number of constant multipliers after folding
   function automatic int prod_count(input int n, input fold_e f);
      case (f)
         FOLD_EVEN: return (n + 1) / 2;
         FOLD_ODD:  return n / 2;
         default:   return n;
      endcase
   endfunction

   // registered adder levels needed for m operands
   function automatic int tree_levels(input int m);
      return (m <= 1) ? 0 : $clog2(m);
   endfunction

endpackage

// File: rtl/fir_tap_line.sv
module fir_tap_line #(
   parameter int DW    = 8,
   parameter int NTAPS = 7
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        ce,
   input  logic [DW-1:0]               x_in,
   output logic [NTAPS-1:0][DW-1:0]    taps
);

   for (genvar g = 0; g < NTAPS; g++) begin : g_tap
      if (g == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  taps[0] <= '0;
            else if (ce) taps[0] <= x_in;
         end
      end else begin : g_body
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  taps[g] <= '0;
            else if (ce) taps[g] <= taps[g-1];
         end
      end
   end

endmodule

// File: rtl/fir_fold_stage.sv
module fir_fold_stage
   import fir_pkg::*;
#(
   parameter int    DW        = 8,
   parameter int    NTAPS     = 7,
   parameter int    M         = 4,
   parameter fold_e FOLD      = FOLD_EVEN,
   parameter bit    SIGNED_IN = 1'b1,
   localparam int   SW        = DW + 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        ce,
   input  logic [NTAPS-1:0][DW-1:0]    taps,
   output logic [M-1:0][SW-1:0]        pre
);

   localparam int HALF = NTAPS / 2;

   logic [M-1:0][SW-1:0] pre_d;

   function automatic logic [SW-1:0] widen(input logic [DW-1:0] raw);
      if (SIGNED_IN) return SW'($signed(raw));
      else           return SW'(raw);
   endfunction

   if (FOLD == FOLD_NONE) begin : g_plain
      for (genvar i = 0; i < M; i++) begin : g_lane
         assign pre_d[i] = widen(taps[i]);
      end
   end else begin : g_folded
      for (genvar i = 0; i < HALF; i++) begin : g_pair
         if (FOLD == FOLD_EVEN) begin : g_add
            assign pre_d[i] = widen(taps[i]) + widen(taps[NTAPS-1-i]);
         end else begin : g_sub
            assign pre_d[i] = widen(taps[i]) - widen(taps[NTAPS-1-i]);
         end
      end
      if (FOLD == FOLD_EVEN && (NTAPS % 2) == 1) begin : g_centre
         assign pre_d[M-1] = widen(taps[HALF]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  pre <= '0;
      else if (ce) pre <= pre_d;
   end

endmodule

// File: rtl/fir_const_mul.sv
module fir_const_mul #(
   parameter int          SW   = 10,
   parameter int          CW   = 8,
   parameter int          OW   = 20,
   parameter logic [CW-1:0] COEF = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ce,
   input  logic [SW-1:0] a,
   output logic [OW-1:0] p
);

   logic signed [OW-1:0] a_x;
   logic signed [OW-1:0] c_x;

   assign a_x = OW'($signed(a));
   assign c_x = OW'($signed(COEF));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  p <= '0;
      else if (ce) p <= a_x * c_x;
   end

endmodule

// File: rtl/fir_sum_tree.sv
module fir_sum_tree #(
   parameter int  W  = 20,
   parameter int  N  = 4,
   parameter int  LV = 2,
   localparam int P  = 1 << LV
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ce,
   input  logic [N-1:0][W-1:0] leaf_in,
   output logic [W-1:0]        total
);

   logic [P-1:0][W-1:0] leaves;

   for (genvar i = 0; i < P; i++) begin : g_leaf
      if (i < N) begin : g_used
         assign leaves[i] = leaf_in[i];
      end else begin : g_pad
         assign leaves[i] = '0;
      end
   end

   if (LV == 0) begin : g_flat
      assign total = leaves[0];
   end else begin : g_heap
      // node j sums children 2j and 2j+1; indices >= P are leaves
      logic [P-1:1][W-1:0]   node;
      logic [2*P-1:1][W-1:0] view;

      for (genvar j = 1; j < 2*P; j++) begin : g_view
         if (j < P) begin : g_int
            assign view[j] = node[j];
         end else begin : g_ext
            assign view[j] = leaves[j-P];
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            node <= '0;
         end else if (ce) begin
            for (int j = 1; j < P; j++) node[j] <= view[2*j] + view[2*j+1];
         end
      end

      assign total = node[1];
   end

endmodule

// File: rtl/fir_sym_pipe.sv
module fir_sym_pipe
   import fir_pkg::*;
#(
   parameter int    DW        = 8,
   parameter int    CW        = 8,
   parameter int    NTAPS     = 7,
   parameter fold_e FOLD      = FOLD_EVEN,
   parameter bit    SIGNED_IN = 1'b1,
   parameter int    OUT_W     = 20,
   parameter logic [NTAPS*CW-1:0] COEFS =
      {8'h03, 8'hF6, 8'h19, 8'h3C, 8'h19, 8'hF6, 8'h03}
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    ce,
   input  logic [DW-1:0]           x_in,
   output logic signed [OUT_W-1:0] y_out,
   output logic                    out_valid
);

   localparam int M      = prod_count(NTAPS, FOLD);
   localparam int LV     = tree_levels(M);
   localparam int SW     = DW + 2;
   localparam int FULL_W = SW + CW + LV;
   localparam int LAT    = 2 + LV;

   if (DW < 4 || DW > 24) begin : g_bad_dw
      $error("fir_sym_pipe: DW out of range 4..24");
   end
   if (CW < 4 || CW > 24) begin : g_bad_cw
      $error("fir_sym_pipe: CW out of range 4..24");
   end
   if (NTAPS < 4 || NTAPS > 100) begin : g_bad_taps
      $error("fir_sym_pipe: NTAPS out of range 4..100");
   end
   if (OUT_W < 1 || OUT_W > FULL_W) begin : g_bad_ow
      $error("fir_sym_pipe: OUT_W exceeds full precision");
   end

   logic [NTAPS-1:0][DW-1:0] taps;
   logic [M-1:0][SW-1:0]     folded;
   logic [M-1:0][FULL_W-1:0] prods;
   logic [FULL_W-1:0]        total;
   logic [LAT:0]             vld_q;

   fir_tap_line #(.DW(DW), .NTAPS(NTAPS)) u_line (
      .clk(clk), .rst_n(rst_n), .ce(ce), .x_in(x_in), .taps(taps)
   );

   fir_fold_stage #(
      .DW(DW), .NTAPS(NTAPS), .M(M), .FOLD(FOLD), .SIGNED_IN(SIGNED_IN)
   ) u_fold (
      .clk(clk), .rst_n(rst_n), .ce(ce), .taps(taps), .pre(folded)
   );

   for (genvar i = 0; i < M; i++) begin : g_mul
      fir_const_mul #(
         .SW(SW), .CW(CW), .OW(FULL_W), .COEF(COEFS[i*CW +: CW])
      ) u_mul (
         .clk(clk), .rst_n(rst_n), .ce(ce), .a(folded[i]), .p(prods[i])
      );
   end

   fir_sum_tree #(.W(FULL_W), .N(M), .LV(LV)) u_tree (
      .clk(clk), .rst_n(rst_n), .ce(ce), .leaf_in(prods), .total(total)
   );

   assign y_out = total[FULL_W-1 -: OUT_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  vld_q <= '0;
      else if (ce) vld_q <= {vld_q[LAT-1:0], 1'b1};
   end

   assign out_valid = vld_q[LAT];

endmodule

// File: rtl/fir_sym_pipe_chk.sv
module fir_sym_pipe_chk #(
   parameter int DW    = 8,
   parameter int NTAPS = 7,
   parameter int OUT_W = 20,
   parameter int LAT   = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ce,
   input logic [DW-1:0]    x_in,
   input logic [OUT_W-1:0] y_out,
   input logic             out_valid
);

   localparam int ZLIM = NTAPS + LAT;

   int en_cnt;
   int z_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_cnt <= 0;
         z_run  <= 0;
      end else if (ce) begin
         if (en_cnt < LAT + 1) en_cnt <= en_cnt + 1;
         if (x_in != '0)       z_run  <= 0;
         else if (z_run < ZLIM) z_run <= z_run + 1;
      end
   end

   assert_ce_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !ce |=> ($stable(y_out) && $stable(out_valid)));

   assert_valid_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> out_valid);

   assert_valid_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == (en_cnt >= LAT + 1));

   assert_flush_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (z_run == ZLIM) |-> (y_out == '0));

endmodule

bind fir_sym_pipe fir_sym_pipe_chk #(
   .DW(DW), .NTAPS(NTAPS), .OUT_W(OUT_W), .LAT(LAT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .ce(ce), .x_in(x_in),
   .y_out(y_out), .out_valid(out_valid)
);

// File: tb/fir_sym_pipe_bench.sv
module fir_sym_pipe_bench;
   import fir_pkg::*;

   localparam int CLK_P = 10;

   // per-instance latency 2 + ceil(log2 M)
   localparam int LAT_A = 4;   // 7 taps even fold, M=4
   localparam int LAT_B = 4;   // 7 taps odd fold, M=3
   localparam int LAT_C = 5;   // 6 taps no fold, M=6

   localparam int CA [7] = '{3, -10, 25, 60, 25, -10, 3};
   localparam int CB [7] = '{5, -20, 70, 0, -70, 20, -5};
   localparam int CC [6] = '{-32, 31, 1, -7, 12, 9};

   // {ce, sample}
   localparam logic [8:0] STIM [24] = '{
      9'h101, 9'h100, 9'h100, 9'h17F, 9'h180, 9'h0AA, 9'h0AA, 9'h155,
      9'h1FF, 9'h110, 9'h0FF, 9'h1C3, 9'h13C, 9'h1E0, 9'h105, 9'h000,
      9'h000, 9'h1A0, 9'h17F, 9'h181, 9'h102, 9'h0FE, 9'h1FE, 9'h133
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ce = 1'b0;
   logic [7:0] x = '0;

   logic signed [19:0] y_a;
   logic signed [19:0] y_b;
   logic signed [11:0] y_c;
   logic v_a, v_b, v_c;

   int nchk = 0;
   int nfail = 0;
   int e_cnt = 0;
   logic [7:0] hist [0:511];

   always #(CLK_P/2) clk = ~clk;

   fir_sym_pipe #(
      .DW(8), .CW(8), .NTAPS(7), .FOLD(FOLD_EVEN), .SIGNED_IN(1'b1), .OUT_W(20),
      .COEFS({8'h03, 8'hF6, 8'h19, 8'h3C, 8'h19, 8'hF6, 8'h03})
   ) u_fir_sym_pipe (
      .clk(clk), .rst_n(rst_n), .ce(ce), .x_in(x), .y_out(y_a), .out_valid(v_a)
   );

   fir_sym_pipe #(
      .DW(8), .CW(8), .NTAPS(7), .FOLD(FOLD_ODD), .SIGNED_IN(1'b0), .OUT_W(20),
      .COEFS({8'hFB, 8'h14, 8'hBA, 8'h00, 8'h46, 8'hEC, 8'h05})
   ) u_fir_sym_pipe_odd (
      .clk(clk), .rst_n(rst_n), .ce(ce), .x_in(x), .y_out(y_b), .out_valid(v_b)
   );

   fir_sym_pipe #(
      .DW(6), .CW(6), .NTAPS(6), .FOLD(FOLD_NONE), .SIGNED_IN(1'b1), .OUT_W(12),
      .COEFS({6'h09, 6'h0C, 6'h39, 6'h01, 6'h1F, 6'h20})
   ) u_fir_sym_pipe_raw (
      .clk(clk), .rst_n(rst_n), .ce(ce), .x_in(x[5:0]), .y_out(y_c), .out_valid(v_c)
   );

   function automatic longint sample_of(input int which, input int j);
      if (j < 1) return 0;
      case (which)
         0:       return longint'($signed(hist[j]));
         1:       return longint'(hist[j]);
         default: return longint'($signed(hist[j][5:0]));
      endcase
   endfunction

   function automatic longint model_y(input int which);
      longint s = 0;
      int lat, n, c;
      lat = (which == 2) ? LAT_C : LAT_A;
      n   = (which == 2) ? 6 : 7;
      for (int k = 0; k < n; k++) begin
         c = (which == 0) ? CA[k] : (which == 1) ? CB[k] : CC[k];
         s += longint'(c) * sample_of(which, e_cnt - lat - k);
      end
      if (which == 2) s = s >>> 5;   // 17-bit sum, 12 bits kept (R6)
      return s;
   endfunction

   task automatic check_val(input string tag, input longint act, input longint exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic check_all(input string tag);
      check_val({tag, " R1 R2 even-fold y"}, longint'(y_a), model_y(0));
      check_val({tag, " R3 R5 odd-fold unsigned y"}, longint'(y_b), model_y(1));
      check_val({tag, " R4 R6 no-fold truncated y"}, longint'(y_c), model_y(2));
      check_val({tag, " R8 valid a"}, longint'(v_a), longint'(e_cnt >= LAT_A + 1));
      check_val({tag, " R8 valid b"}, longint'(v_b), longint'(e_cnt >= LAT_B + 1));
      check_val({tag, " R8 valid c"}, longint'(v_c), longint'(e_cnt >= LAT_C + 1));
   endtask

   // drive at a falling edge, model the rising edge, check at the next falling edge
   task automatic step(input logic [7:0] xv, input logic cev, input string tag);
      x  = xv;
      ce = cev;
      @(posedge clk);
      if (cev && rst_n) begin
         e_cnt++;
         hist[e_cnt] = xv;
      end
      @(negedge clk);
      check_all(cev ? tag : {tag, " R7 hold"});
   endtask

   task automatic hold_run(input logic [7:0] xv, input int n, input string tag);
      for (int i = 0; i < n; i++) step(xv, 1'b1, tag);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check_val("R9 reset y a", longint'(y_a), 0);
      check_val("R9 reset y c", longint'(y_c), 0);
      check_val("R9 reset valid", longint'({v_a, v_b, v_c}), 0);
      rst_n = 1'b1;

      // table walk
      for (int i = 0; i < 24; i++) step(STIM[i][7:0], STIM[i][8], "table");

      // reset in mid-run
      @(negedge clk);
      x = 8'h55; ce = 1'b1;
      rst_n = 1'b0;
      #1;
      check_val("R9 async clear y b", longint'(y_b), 0);
      check_val("R9 async clear valid", longint'({v_a, v_b, v_c}), 0);
      @(negedge clk);
      check_val("R9 held clear y a", longint'(y_a), 0);
      rst_n = 1'b1;
      e_cnt = 0;

      // impulse: reads back each coefficient position
      step(8'h01, 1'b1, "impulse");
      hold_run(8'h00, 12, "impulse tail");

      // stalls inside a run
      step(8'h40, 1'b1, "stall");
      step(8'h11, 1'b0, "stall R7");
      step(8'h22, 1'b0, "stall R7");
      step(8'h33, 1'b1, "stall");

      // full-scale runs
      hold_run(8'h80, 12, "R11 most negative a");
      hold_run(8'hFF, 12, "R11 largest unsigned b");
      hold_run(8'hA0, 12, "R11 most negative c");

      // flush
      hold_run(8'h00, 12, "R10 flush");
      check_val("R10 zero a", longint'(y_a), 0);
      check_val("R10 zero b", longint'(y_b), 0);
      check_val("R10 zero c", longint'(y_c), 0);

      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

   initial begin
      #(CLK_P * 200000);
      nchk++;
      nfail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

endmodule